// File: doc/BRIEF.md
# Open-Row-Preferring Bank Request Scheduler

This block sits in front of a single DRAM bank. It holds a small pool of pending memory requests, each with a row, a column and a requester tag. Whenever the bank is free it sends one of them to the bank. A request that targets the row already latched in the bank's row buffer is always sent before one that would force a different row to be opened. Among requests in the same class, the one that has waited longest goes first.

The bank is modelled with one open-row register and fixed service times. A request to the open row is served quickly. A request to a different row must first close that row and then open the new one, so it takes much longer. A request that arrives while no row is open has a middle cost. Only one access is in service at a time. When an access finishes, a one-cycle response returns its tag, its row and column, and the class of access it turned out to be.

Requests enter through a valid/ready handshake. A run of requests to one row can be served back to back, ahead of an older request to another row.

Top module: `rowhit_sched`

## Requirements
- R1: When the bank takes a new access and at least one pending request matches the open row, the chosen request is one that matches the open row.
- R2: Among pending requests of the same match class, the one accepted earliest is chosen first. If ages are equal after saturation, the lowest buffer slot wins.
- R3: Service time is counted between consecutive responses while requests are waiting. It is LAT_HIT (default 4) cycles for a hit, LAT_EMPTY (default 8) for an empty access and LAT_CONFLICT (default 12) for a conflict. Only one access is in service at a time.
- R4: The bank holds exactly one open row. Every access leaves its own row open, so a conflict replaces the previous open row.
- R5: After reset no row is open, so the first access is reported as an empty access.
- R6: A request is accepted on a clock edge where req_valid and req_ready are both high. req_ready is low exactly when all DEPTH (default 8) slots hold pending requests.
- R7: rsp_valid is high for one cycle per completed access. In that cycle rsp_tid, rsp_row and rsp_col echo the request, and rsp_kind encodes the access class: 0 hit, 1 empty, 2 conflict.
- R8: During and right after reset, req_ready is 1 and rsp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | A free slot exists |
| req_row | input | ROW_W (14) | Row of the offered request |
| req_col | input | COL_W (7) | Column of the offered request |
| req_tid | input | TID_W (2) | Requester tag |
| rsp_valid | output | 1 | An access completes this cycle |
| rsp_tid | output | TID_W (2) | Tag of the completed request |
| rsp_row | output | ROW_W (14) | Row of the completed request |
| rsp_col | output | COL_W (7) | Column of the completed request |
| rsp_kind | output | 2 | 0 hit, 1 empty, 2 conflict |

## Verification
The hardest state to reach from the ports is a full buffer that holds a mix of hits and conflicts, waiting while a slow access is in service. Without that backlog each request is served on arrival and the ordering policy is never used. Each run therefore starts with a request to a fresh row, which is served as a slow empty or conflict access. Eight more requests arrive while it is in service. Their rows follow the bits of a sweep value over all 256 combinations of two rows. The bench predicts the full service order, the access classes and the gaps between responses, and checks that ready drops when the buffer fills.

// File: rtl/rhs_pkg.sv
package rhs_pkg;
   typedef enum logic [1:0] {
      KIND_HIT      = 2'd0,
      KIND_EMPTY    = 2'd1,
      KIND_CONFLICT = 2'd2
   } acc_kind_e;
endpackage

// File: rtl/rhs_pick.sv
module rhs_pick #(
   parameter int N     = 8,
   parameter int AGE_W = 8,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]       vld,
   input  logic [N-1:0]       hit,
   input  logic [N*AGE_W-1:0] ages,
   output logic               any,
   output logic [IDX_W-1:0]   idx
);
   logic             best_hit;
   logic [AGE_W-1:0] best_age;

   always_comb begin
      any      = 1'b0;
      idx      = '0;
      best_hit = 1'b0;
      best_age = '0;
      for (int i = 0; i < N; i++) begin
         if (vld[i] && (!any || (hit[i] && !best_hit) ||
             (hit[i] == best_hit && ages[i*AGE_W +: AGE_W] > best_age))) begin
            any      = 1'b1;
            idx      = IDX_W'(i);
            best_hit = hit[i];
            best_age = ages[i*AGE_W +: AGE_W];
         end
      end
   end
endmodule

// File: rtl/rhs_bank.sv
module rhs_bank
   import rhs_pkg::*;
#(
   parameter int ROW_W        = 14,
   parameter int LAT_HIT      = 4,
   parameter int LAT_EMPTY    = 8,
   parameter int LAT_CONFLICT = 12,
   localparam int CNT_W = $clog2(LAT_CONFLICT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue,
   input  logic [ROW_W-1:0] issue_row,
   output logic             can_issue,
   output logic             done,
   output logic             open_vld,
   output logic [ROW_W-1:0] open_row,
   output acc_kind_e        issue_kind
);
   generate
      if (LAT_HIT < 2 || LAT_EMPTY <= LAT_HIT || LAT_CONFLICT <= LAT_EMPTY) begin : g_bad_lat
         $error("latencies must satisfy 2 <= hit < empty < conflict");
      end
   endgenerate

   logic             busy;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lat_sel;

   always_comb begin
      if (!open_vld)                  issue_kind = KIND_EMPTY;
      else if (issue_row == open_row) issue_kind = KIND_HIT;
      else                            issue_kind = KIND_CONFLICT;
      case (issue_kind)
         KIND_HIT:   lat_sel = CNT_W'(LAT_HIT - 1);
         KIND_EMPTY: lat_sel = CNT_W'(LAT_EMPTY - 1);
         default:    lat_sel = CNT_W'(LAT_CONFLICT - 1);
      endcase
   end

   assign done      = busy && (cnt == '0);
   assign can_issue = !busy || done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         cnt      <= '0;
         open_vld <= 1'b0;
         open_row <= '0;
      end else if (issue) begin
         busy     <= 1'b1;
         cnt      <= lat_sel;
         open_vld <= 1'b1;
         open_row <= issue_row;
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else           cnt  <= cnt - 1'b1;
      end
   end

   // R4
   open_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue |=> open_vld && open_row == $past(issue_row));
   // R7
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R3
   one_inflight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |-> !issue);
endmodule

// File: rtl/rowhit_sched.sv
module rowhit_sched
   import rhs_pkg::*;
#(
   parameter int DEPTH        = 8,
   parameter int ROW_W        = 14,
   parameter int COL_W        = 7,
   parameter int TID_W        = 2,
   parameter int AGE_W        = 8,
   parameter int LAT_HIT      = 4,
   parameter int LAT_EMPTY    = 8,
   parameter int LAT_CONFLICT = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [ROW_W-1:0] req_row,
   input  logic [COL_W-1:0] req_col,
   input  logic [TID_W-1:0] req_tid,
   output logic             rsp_valid,
   output logic [TID_W-1:0] rsp_tid,
   output logic [ROW_W-1:0] rsp_row,
   output logic [COL_W-1:0] rsp_col,
   output logic [1:0]       rsp_kind
);
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [AGE_W-1:0] AGE_MAX = '1;

   generate
      if (DEPTH < 2 || AGE_W < 2) begin : g_bad_cfg
         $error("DEPTH and AGE_W must be at least 2");
      end
   endgenerate

   logic [DEPTH-1:0]       ent_vld, ent_hit;
   logic [ROW_W-1:0]       ent_row [DEPTH];
   logic [COL_W-1:0]       ent_col [DEPTH];
   logic [TID_W-1:0]       ent_tid [DEPTH];
   logic [DEPTH*AGE_W-1:0] ent_age;

   logic             accept, issue, pick_any, can_issue, done, open_vld;
   logic [IDX_W-1:0] alloc_idx, pick_idx;
   logic [ROW_W-1:0] open_row;
   acc_kind_e        issue_kind;

   assign req_ready = !(&ent_vld);
   assign accept    = req_valid && req_ready;
   assign issue     = pick_any && can_issue;

   always_comb begin
      alloc_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--)
         if (!ent_vld[i]) alloc_idx = IDX_W'(i);
   end

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_ent
         assign ent_hit[g] = open_vld && (ent_row[g] == open_row);
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ent_vld[g] <= 1'b0;
               ent_row[g] <= '0;
               ent_col[g] <= '0;
               ent_tid[g] <= '0;
               ent_age[g*AGE_W +: AGE_W] <= '0;
            end else if (accept && alloc_idx == IDX_W'(g)) begin
               ent_vld[g] <= 1'b1;
               ent_row[g] <= req_row;
               ent_col[g] <= req_col;
               ent_tid[g] <= req_tid;
               ent_age[g*AGE_W +: AGE_W] <= '0;
            end else if (issue && pick_idx == IDX_W'(g)) begin
               ent_vld[g] <= 1'b0;
            end else if (ent_vld[g] && ent_age[g*AGE_W +: AGE_W] != AGE_MAX) begin
               ent_age[g*AGE_W +: AGE_W] <= ent_age[g*AGE_W +: AGE_W] + 1'b1;
            end
         end
      end
   endgenerate

   rhs_pick #(.N(DEPTH), .AGE_W(AGE_W)) u_pick (
      .vld  (ent_vld),
      .hit  (ent_hit),
      .ages (ent_age),
      .any  (pick_any),
      .idx  (pick_idx)
   );

   rhs_bank #(
      .ROW_W(ROW_W), .LAT_HIT(LAT_HIT),
      .LAT_EMPTY(LAT_EMPTY), .LAT_CONFLICT(LAT_CONFLICT)
   ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .issue      (issue),
      .issue_row  (ent_row[pick_idx]),
      .can_issue  (can_issue),
      .done       (done),
      .open_vld   (open_vld),
      .open_row   (open_row),
      .issue_kind (issue_kind)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_tid  <= '0;
         rsp_row  <= '0;
         rsp_col  <= '0;
         rsp_kind <= '0;
      end else if (issue) begin
         rsp_tid  <= ent_tid[pick_idx];
         rsp_row  <= ent_row[pick_idx];
         rsp_col  <= ent_col[pick_idx];
         rsp_kind <= issue_kind;
      end
   end
   assign rsp_valid = done;

   // R1
   hit_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && (|(ent_hit & ent_vld))) |-> ent_hit[pick_idx]);
   // R6
   accept_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> ent_vld != '0);
   // R7
   rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !issue |=> $stable(rsp_row) && $stable(rsp_col) && $stable(rsp_kind));
   // R5
   first_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && !open_vld) |-> issue_kind == KIND_EMPTY);
endmodule

// File: tb/sim_rowhit_sched.sv
module sim_rowhit_sched;
   localparam int LH = 4, LE = 8, LC = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [13:0] req_row = '0;
   logic [6:0]  req_col = '0;
   logic [1:0]  req_tid = '0;
   logic        rsp_valid;
   logic [1:0]  rsp_tid;
   logic [13:0] rsp_row;
   logic [6:0]  rsp_col;
   logic [1:0]  rsp_kind;

   always #5 clk = ~clk;

   rowhit_sched u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_row(req_row), .req_col(req_col), .req_tid(req_tid),
      .rsp_valid(rsp_valid), .rsp_tid(rsp_tid), .rsp_row(rsp_row),
      .rsp_col(rsp_col), .rsp_kind(rsp_kind)
   );

   int nvec = 0, nfail = 0, cyc = 0, last_cyc = 0, ridx = 0;
   bit run_active = 0;
   int exp_row[9], exp_col[9], exp_tid[9], exp_kind[9], exp_lat[9];
   bit m_open_vld = 0;
   int m_open_row = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nvec++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   function automatic int lat_of(input int k);
      return (k == 0) ? LH : (k == 1) ? LE : LC;
   endfunction

   always @(posedge clk) cyc++;

   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (!run_active || ridx > 8) begin
            chk(0, "R7 unexpected response", 1, 0);
         end else begin
            chk(rsp_col == exp_col[ridx], "R1/R2 order col", rsp_col, exp_col[ridx]);
            chk(rsp_row == exp_row[ridx], "R7 row", rsp_row, exp_row[ridx]);
            chk(rsp_tid == exp_tid[ridx], "R7 tid", rsp_tid, exp_tid[ridx]);
            chk(rsp_kind == exp_kind[ridx], "R4/R5 kind", rsp_kind, exp_kind[ridx]);
            chk(cyc - last_cyc == exp_lat[ridx], "R3 latency", cyc - last_cyc, exp_lat[ridx]);
            last_cyc = cyc;
            ridx++;
         end
      end
   end

   task automatic run(input int p);
      int  rows[9];
      bit  taken[9];
      int  rb, k, pick;
      rb = p[0] ? 14'h3FFF : 14'h0456;
      rows[0] = 14'h2000 + p;
      for (int i = 1; i < 9; i++) rows[i] = p[i-1] ? 14'h0123 : rb;
      // reference order: open-row matches first, then arrival order
      k = !m_open_vld ? 1 : (rows[0] == m_open_row ? 0 : 2);
      exp_row[0] = rows[0]; exp_col[0] = 8 * (p % 8); exp_tid[0] = 0;
      exp_kind[0] = k; exp_lat[0] = lat_of(k);
      m_open_vld = 1; m_open_row = rows[0];
      for (int i = 0; i < 9; i++) taken[i] = 0;
      for (int s = 1; s < 9; s++) begin
         pick = -1;
         for (int i = 1; i < 9; i++)
            if (!taken[i] && pick < 0 && rows[i] == m_open_row) pick = i;
         if (pick < 0)
            for (int i = 1; i < 9; i++)
               if (!taken[i] && pick < 0) pick = i;
         taken[pick] = 1;
         k = (rows[pick] == m_open_row) ? 0 : 2;
         exp_row[s] = rows[pick]; exp_col[s] = pick + 8 * (p % 8);
         exp_tid[s] = pick % 4; exp_kind[s] = k; exp_lat[s] = lat_of(k);
         m_open_row = rows[pick];
      end
      ridx = 0;
      run_active = 1;
      for (int i = 0; i < 9; i++) begin
         @(negedge clk);
         if (i == 0) last_cyc = cyc + 1;
         chk(req_ready == 1'b1, "R6 ready with free slot", req_ready, 1);
         req_valid = 1'b1;
         req_row = 14'(rows[i]);
         req_col = 7'(i + 8 * (p % 8));
         req_tid = 2'(i % 4);
      end
      @(negedge clk);
      chk(req_ready == 1'b0, "R6 ready low when full", req_ready, 0);
      req_valid = 1'b0;
      while (ridx < 9) @(negedge clk);
      run_active = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1, "R8 reset ready", req_ready, 1);
      chk(rsp_valid == 1'b0, "R8 reset rsp_valid", rsp_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R8 ready after reset", req_ready, 1);
      chk(rsp_valid == 1'b0, "R8 idle after reset", rsp_valid, 0);
      for (int p = 0; p < 256; p++) run(p);
      repeat (20) @(negedge clk);
      chk(rsp_valid == 1'b0, "R7 idle after drain", rsp_valid, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nvec++;
      nfail++;
      $display("FAIL watchdog R3 actual=%0d expected=%0d", ridx, 9);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule